// File: doc/BRIEF.md
# Character-Cell VGA Display Generator

This block drives a monochrome VGA monitor from a character-cell screen image held in a byte-wide RAM with a separate read port for video. It counts pixels and lines to produce horizontal and vertical sync. For every visible text line it reads the character code for each cell from the lower part of the RAM. It then reads the matching glyph row from a font area in the upper part of the same RAM. The glyph bits are shifted out one per pixel clock, leftmost pixel first.

A character cell is 8 pixels wide. Each text row is 8 glyph lines followed by empty spacer lines. A code whose top bit is set is drawn with its pixels inverted. A scroll register sets which stored row appears at the top of the screen. The rows below it follow in order and wrap around from the last stored row back to the first. The processor's write side of the RAM lies outside this block. The block only issues read addresses and takes read data back one cycle later.

Top module: `vga_text_gen`

## Requirements
- R1: `hsync_n` is low for exactly `H_SYNC` pixels per line. The low pulse starts `H_VIS + H_FP` pixels after the start of the line. A line is `H_VIS + H_FP + H_SYNC + H_BP` pixels long.
- R2: `vsync_n` is low for exactly `V_SYNC` whole lines. The low pulse starts at line `V_VIS + V_FP` of a frame. A frame is `V_VIS + V_FP + V_SYNC + V_BP` lines long.
- R3: Pixel x of glyph line g in display row r, taken with scroll 0, comes from the byte `C` stored at RAM offset `r*COLS + x/8`. Its value is bit `7 - x%8` of the font byte at `COLS*ROWS + 8*C[6:0] + g`, so the MSB is the leftmost pixel.
- R4: Each text row spans `8 + BLANK_LINES` scanlines. The scanlines after the eighth are dark across the whole line.
- R5: When bit 7 of a character code is 1, all 8 pixels of every glyph line of that cell are the complement of the font byte.
- R6: With an active scroll value s, display row r shows stored row `(r + s) mod ROWS`. A value written during a frame takes effect at the start of the next frame.
- R7: A scroll write with a value of `ROWS` or more is ignored, and the previous scroll value stays in force.
- R8: `pix` is 0 for every pixel right of the text area (x >= 8*COLS) and for every line at or below `ROWS*(8+BLANK_LINES)`.
- R9: During and after reset `hsync_n` and `vsync_n` are 1, `pix` is 0, and the scroll value is 0. The output timeline, made up of syncs and pixels together, runs exactly 9 cycles behind the internal pixel and line counters, which restart at 0 when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| scroll_we | input | 1 | Write strobe for the scroll register |
| scroll_val | input | ROW_W | Row offset to load (legal: 0 to ROWS-1) |
| ram_addr | output | ADDR_W | Registered video-side RAM read address |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the address |
| hsync_n | output | 1 | Horizontal sync, active low, registered |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| pix | output | 1 | Monochrome pixel, registered |

## Verification
Any error in the fetch phase or the RAM latency assumption puts wrong glyph bits on `pix` within the first 8-pixel cell after it happens. A misaligned shift register moves every cell sideways by whole pixels, which the per-pixel compare catches on the first visible line. An error in the row or scroll counters shows only once the next text row or the next frame begins. It is then caught because the bench writes different random text into every row and changes the scroll value between frames. An error in the delay between counters and outputs shows as a sync edge that is off by a few pixels against the expected pulse window.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int GLYPH_W    = 8;
  localparam int GLYPH_H    = 8;
  localparam int FONT_CODES = 128;
  localparam int FONT_BYTES = FONT_CODES * GLYPH_H;
  // counter -> ram addr -> code -> font addr -> font -> shifter -> pix reg
  localparam int PIPE_LAT   = 9;

  typedef struct packed {
    logic hs_n;
    logic vs_n;
  } sync_t;

  localparam sync_t SYNC_IDLE = '{hs_n: 1'b1, vs_n: 1'b1};

  function automatic logic [GLYPH_W-1:0] glyph_bits(input logic [GLYPH_W-1:0] font,
                                                    input logic inv);
    return font ^ {GLYPH_W{inv}};
  endfunction

endpackage

// File: rtl/vtg_delay.sv
module vtg_delay #(
  parameter int W = 1,
  parameter int DEPTH = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/vtg_timing.sv
module vtg_timing
  import vtg_pkg::*;
#(
  parameter int COLS        = 64,
  parameter int ROWS        = 48,
  parameter int BLANK_LINES = 2,
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int HW     = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scroll_we,
  input  logic [ROW_W-1:0] scroll_val,
  output logic [HW-1:0]    hcnt,
  output logic             glyph_line,
  output logic [2:0]       font_line,
  output logic [ROW_W-1:0] mem_row,
  output sync_t            sync_raw
);

  localparam int H_TOTAL    = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL    = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int VW         = $clog2(V_TOTAL);
  localparam int ROW_LINES  = GLYPH_H + BLANK_LINES;
  localparam int SUBW       = $clog2(ROW_LINES);
  localparam int TEXT_LINES = ROWS * ROW_LINES;

  localparam logic [HW-1:0]    H_LAST     = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0]    HS_BEGIN   = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0]    HS_END     = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0]    V_LAST     = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0]    VS_BEGIN   = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0]    VS_END     = VW'(V_VIS + V_FP + V_SYNC);
  localparam logic [VW-1:0]    TEXT_END   = VW'(TEXT_LINES);
  localparam logic [SUBW-1:0]  SUB_LAST   = SUBW'(ROW_LINES - 1);
  localparam logic [SUBW-1:0]  SUB_GLYPH  = SUBW'(GLYPH_H);
  localparam logic [ROW_W-1:0] ROW_LAST   = ROW_W'(ROWS - 1);
  localparam logic [ROW_W:0]   ROWS_LIMIT = (ROW_W+1)'(ROWS);

  logic [VW-1:0]    vcnt;
  logic [SUBW-1:0]  sub;
  logic [ROW_W-1:0] scroll_q;
  logic             scroll_ok;

  assign scroll_ok = scroll_we && ({1'b0, scroll_val} < ROWS_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      scroll_q <= '0;
    end else if (scroll_ok) begin
      scroll_q <= scroll_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      vcnt    <= '0;
      sub     <= '0;
      mem_row <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      if (vcnt == V_LAST) begin
        vcnt    <= '0;
        sub     <= '0;
        mem_row <= scroll_q;
      end else begin
        vcnt <= vcnt + 1'b1;
        if (sub == SUB_LAST) begin
          sub     <= '0;
          mem_row <= (mem_row == ROW_LAST) ? '0 : mem_row + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign glyph_line    = (vcnt < TEXT_END) && (sub < SUB_GLYPH);
  assign font_line     = sub[2:0];
  assign sync_raw.hs_n = !((hcnt >= HS_BEGIN) && (hcnt < HS_END));
  assign sync_raw.vs_n = !((vcnt >= VS_BEGIN) && (vcnt < VS_END));

  AST_HCNT_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    hcnt <= H_LAST); // R1
  AST_VSYNC_EDGE_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(sync_raw.vs_n) |-> (hcnt == '0)); // R2
  AST_SCROLL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    {1'b0, scroll_q} < ROWS_LIMIT); // R7
  AST_MEMROW_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mem_row <= ROW_LAST); // R6
  AST_SCROLL_HOLD_ON_BAD: assert property (@(posedge clk) disable iff (rst)
    (scroll_we && !scroll_ok) |=> $stable(scroll_q)); // R7

endmodule

// File: rtl/vtg_fetch.sv
module vtg_fetch
  import vtg_pkg::*;
#(
  parameter int COLS   = 64,
  parameter int ROWS   = 48,
  parameter int ADDR_W = 12,
  parameter int HW     = 10,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HW-1:0]     hcnt,
  input  logic              glyph_line,
  input  logic [2:0]        font_line,
  input  logic [ROW_W-1:0]  mem_row,
  input  logic [7:0]        ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              pix
);

  localparam int TEXT_W = COLS * GLYPH_W;
  localparam logic [HW-1:0]     TEXT_W_C  = HW'(TEXT_W);
  localparam logic [ADDR_W-1:0] FONT_BASE = ADDR_W'(COLS * ROWS);

  logic [2:0]         phase;
  logic [HW-4:0]      col;
  logic               in_text;
  logic [ADDR_W-1:0]  text_addr;
  logic [ADDR_W-1:0]  font_addr;
  logic               act_q;
  logic               inv_q;
  logic [7:0]         font_q;
  logic [GLYPH_W-1:0] shift_q;

  assign phase     = hcnt[2:0];
  assign col       = hcnt[HW-1:3];
  assign in_text   = glyph_line && (hcnt < TEXT_W_C);
  assign text_addr = ADDR_W'(mem_row) * ADDR_W'(COLS) + ADDR_W'(col);
  assign font_addr = FONT_BASE + ADDR_W'({ram_rdata[6:0], font_line});

  // cell schedule: p0 text addr, p2 code in / font addr, p4 font in, p7 load
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr <= '0;
      act_q    <= 1'b0;
      inv_q    <= 1'b0;
      font_q   <= '0;
    end else begin
      case (phase)
        3'd0: begin
          ram_addr <= text_addr;
          act_q    <= in_text;
        end
        3'd2: begin
          ram_addr <= font_addr;
          inv_q    <= ram_rdata[7];
        end
        3'd4: font_q <= ram_rdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      pix     <= 1'b0;
    end else begin
      if (phase == 3'd7) shift_q <= act_q ? glyph_bits(font_q, inv_q) : '0;
      else               shift_q <= {shift_q[GLYPH_W-2:0], 1'b0};
      pix <= shift_q[GLYPH_W-1];
    end
  end

  AST_TEXT_FETCH_IN_TEXT_AREA: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd1 && act_q) |-> (ram_addr < FONT_BASE)); // R3
  AST_FONT_FETCH_IN_FONT_AREA: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3 && act_q) |-> (ram_addr >= FONT_BASE)); // R3
  AST_IDLE_CELL_DARK: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd7 && !act_q) |=> (shift_q == '0)); // R8
  AST_BLANK_LINE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && !glyph_line) |=> !act_q); // R4

endmodule

// File: rtl/vga_text_gen.sv
module vga_text_gen
  import vtg_pkg::*;
#(
  parameter int COLS        = 64,
  parameter int ROWS        = 48,
  parameter int BLANK_LINES = 2,
  parameter int ADDR_W      = 12,
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scroll_we,
  input  logic [ROW_W-1:0]  scroll_val,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [7:0]        ram_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              pix
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int HW      = $clog2(H_TOTAL);

  logic [HW-1:0]    hcnt;
  logic             glyph_line;
  logic [2:0]       font_line;
  logic [ROW_W-1:0] mem_row;
  sync_t            sync_raw;
  sync_t            sync_out;

  vtg_timing #(
    .COLS(COLS), .ROWS(ROWS), .BLANK_LINES(BLANK_LINES),
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .ROW_W(ROW_W)
  ) u_timing (
    .clk(clk), .rst(rst),
    .scroll_we(scroll_we), .scroll_val(scroll_val),
    .hcnt(hcnt), .glyph_line(glyph_line), .font_line(font_line),
    .mem_row(mem_row), .sync_raw(sync_raw)
  );

  vtg_fetch #(
    .COLS(COLS), .ROWS(ROWS), .ADDR_W(ADDR_W), .HW(HW), .ROW_W(ROW_W)
  ) u_fetch (
    .clk(clk), .rst(rst),
    .hcnt(hcnt), .glyph_line(glyph_line), .font_line(font_line),
    .mem_row(mem_row), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .pix(pix)
  );

  vtg_delay #(
    .W($bits(sync_t)), .DEPTH(PIPE_LAT), .RST_VAL(SYNC_IDLE)
  ) u_sync_dly (
    .clk(clk), .rst(rst), .din(sync_raw), .dout(sync_out)
  );

  assign hsync_n = sync_out.hs_n;
  assign vsync_n = sync_out.vs_n;

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (hsync_n && vsync_n && !pix)); // R9
  AST_NO_PIXEL_IN_HSYNC: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !pix); // R8

endmodule

// File: tb/vga_text_gen_tb.sv
module vga_text_gen_tb;

  localparam int COLS = 4, ROWS = 3, BLANK = 2, ADDR_W = 12;
  localparam int H_VIS = 40, H_FP = 4, H_SYNC = 8, H_BP = 4;
  localparam int V_VIS = 30, V_FP = 2, V_SYNC = 2, V_BP = 3;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int ROW_LINES = 8 + BLANK;
  localparam int TEXT_W = COLS * 8;
  localparam int TEXT_LINES = ROWS * ROW_LINES;
  localparam int FONT_BASE = COLS * ROWS;
  localparam int LAT = 9;
  localparam int NFRAMES = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scroll_we = 1'b0;
  logic [1:0] scroll_val = '0;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0] ram_rdata;
  logic hsync_n, vsync_n, pix;

  logic [7:0] mem [0:4095];
  int frame_scroll [0:63];
  bit frame_ign [0:63];
  int model_scroll = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) ram_rdata <= mem[ram_addr];

  vga_text_gen #(
    .COLS(COLS), .ROWS(ROWS), .BLANK_LINES(BLANK), .ADDR_W(ADDR_W),
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_dut (
    .clk(clk), .rst(rst), .scroll_we(scroll_we), .scroll_val(scroll_val),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .pix(pix)
  );

  function automatic bit exp_hs(int d);
    int h;
    if (d < 0) return 1'b1;
    h = d % H_TOT;
    return !(h >= H_VIS + H_FP && h < H_VIS + H_FP + H_SYNC);
  endfunction

  function automatic bit exp_vs(int d);
    int v;
    if (d < 0) return 1'b1;
    v = (d / H_TOT) % V_TOT;
    return !(v >= V_VIS + V_FP && v < V_VIS + V_FP + V_SYNC);
  endfunction

  function automatic bit exp_pix(int d);
    int h, v, f, sub, r;
    logic [7:0] code, fb;
    if (d < 0) return 1'b0;
    f = d / FRAME; h = d % H_TOT; v = (d / H_TOT) % V_TOT;
    if (h >= TEXT_W || v >= TEXT_LINES) return 1'b0;
    sub = v % ROW_LINES;
    if (sub >= 8) return 1'b0;
    r = (v / ROW_LINES + frame_scroll[f]) % ROWS;
    code = mem[r * COLS + h / 8];
    fb = mem[FONT_BASE + int'(code[6:0]) * 8 + sub];
    return fb[7 - h % 8] ^ code[7];
  endfunction

  function automatic string pix_tag(int d);
    int h, v, f, r;
    logic [7:0] code;
    if (d < 0) return "R9";
    f = d / FRAME; h = d % H_TOT; v = (d / H_TOT) % V_TOT;
    if (h >= TEXT_W || v >= TEXT_LINES) return "R8";
    if (v % ROW_LINES >= 8) return "R4";
    if (frame_ign[f]) return "R7";
    r = (v / ROW_LINES + frame_scroll[f]) % ROWS;
    code = mem[r * COLS + h / 8];
    if (code[7]) return "R5";
    if (frame_scroll[f] != 0) return "R6";
    return "R3";
  endfunction

  task automatic check_bit(string req, string what, int t, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at t=%0d: actual=%0b expected=%0b", req, what, t, act, exp);
    end
  endtask

  task automatic fill_text(int nf);
    for (int i = 0; i < COLS * ROWS; i++) mem[i] = 8'($urandom);
    if (nf == 1) begin
      mem[0] = 8'h80;  // inverted empty glyph -> all lit (R5)
      mem[1] = 8'hFF;  // inverted full glyph -> all dark (R5)
      mem[2] = 8'h7F;  // full glyph, top bit clear (R3)
      mem[3] = 8'h00;
    end
  endtask

  initial begin
    int wval;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin frame_scroll[i] = 0; frame_ign[i] = 1'b0; end
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    for (int g = 0; g < 8; g++) begin
      mem[FONT_BASE + g] = 8'h00;
      mem[FONT_BASE + 127 * 8 + g] = 8'hFF;
    end
    for (int i = 0; i < COLS * ROWS; i++) mem[i] = 8'(i + 8'h21); // R3 directed frame 0
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < NFRAMES * FRAME + LAT; t++) begin
      int d, hc, vc, fc;
      if (t > 0) @(negedge clk);
      d = t - LAT;
      if (t % FRAME == 0) frame_scroll[t / FRAME] = model_scroll;
      check_bit((d < 0) ? "R9" : "R1", "hsync_n", t, hsync_n, exp_hs(d));
      check_bit((d < 0) ? "R9" : "R2", "vsync_n", t, vsync_n, exp_vs(d));
      check_bit(pix_tag(d), "pix", t, pix, exp_pix(d));
      scroll_we = 1'b0;
      fc = t / FRAME; hc = t % H_TOT; vc = (t / H_TOT) % V_TOT;
      if (vc == V_VIS + 1 && hc == 0) fill_text(fc + 1);
      if (vc == 5 && hc == 3) begin
        case (fc)
          0: wval = 1;
          1: wval = ROWS - 1;
          2: wval = ROWS;      // illegal, must be ignored (R7)
          3: wval = 0;
          default: wval = int'($urandom % 4);
        endcase
        scroll_we = 1'b1;
        scroll_val = 2'(wval);
        if (wval < ROWS) model_scroll = wval;
        else frame_ign[fc + 1] = 1'b1;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1-related timeline) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule